// File: doc/BRIEF.md
# Banked Byte Register File with Pointer Access

This block is the data space of a small accumulator processor. It stores bytes only. It combines general-purpose RAM with a few special locations, and the core reaches every one of them through a short direct address. A bank register supplies the upper address bits, so the full space is `2^(DIR_AW+BANK_W)` bytes. The special locations sit at the same offsets in every bank. They are the pointer, the status byte, the program-counter low byte, the bank register and five virtual indirect slots.

Any access to an indirect slot goes to the full address held in the pointer, and the bank register plays no part. Four of the slots also step the pointer by one. Two of them step it after the access and two step it before, so the pointer can serve as a stack pointer. The ALU writes the status flags through a side port under a per-flag mask. The program-counter low byte is not stored in this block: reads return the core's value, and writes are passed back out as a load request.

The core drives `addr_i` together with `rd_en_i` and/or `we_i` for one cycle. Read data is combinational from the current address and state. Writes, pointer steps, bank changes and flag updates all take effect at the next rising edge.

Top module: `banked_regfile`

## Requirements
- R1: After an asynchronous reset, the pointer, the status byte, the bank register and every RAM byte read as 0.
- R2: A direct address of 9 or more reaches RAM at full address `{bank, addr_i}`. A write appears on `rdata_o` from the next cycle. Each bank has its own storage.
- R3: Direct offsets 0 to 8 select the same special locations whatever the bank value. Offset 5 is the pointer, 6 the status byte, 7 the program-counter low byte and 8 the bank register.
- R4: Offset 0 accesses the byte at the full address held in the pointer, independent of the bank register, and leaves the pointer unchanged.
- R5: Offset 1 (post-increment) and offset 2 (post-decrement) access the location at the pointer. If `rd_en_i` or `we_i` is high, the pointer then changes by +1 or -1 at the edge, modulo `2^(DIR_AW+BANK_W)`.
- R6: Offset 3 (pre-increment) and offset 4 (pre-decrement) access the location at pointer+1 or pointer-1, and that value becomes the pointer at the edge.
- R7: If the pointer's low `DIR_AW` bits name an indirect slot (0 to 4), an indirect access reads 0 and its write is dropped. Any step of the pointer still takes place.
- R8: The status byte can be read and written like any register. With no core write, each bit `i < NFLAG` whose `flag_we_i[i]` is high takes `flag_i[i]` at the edge. `status_o` always shows the stored byte.
- R9: When the core writes the status byte in the same cycle as a flag update, masked flag bits take `flag_i`. All other bits take the written data.
- R10: A read of the program-counter low byte returns `pc_lo_i`. A write to it, direct or indirect, raises `pc_load_o` in the same cycle with `pc_load_data_o` equal to `wdata_i`.
- R11: An indirect write whose target is the pointer stores the written data, and that data wins over the step of the same access.
- R12: The bank register reads back its `BANK_W` bits in the low bits, with the upper bits 0. A write keeps only the low `BANK_W` bits of the data.
- R13: With `rd_en_i` and `we_i` both low, the pointer does not change, even when `addr_i` is a stepping slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | DIR_AW | Direct address from the core |
| rd_en_i | input | 1 | Read strobe (steps the pointer on stepping slots) |
| we_i | input | 1 | Write enable |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational |
| flag_we_i | input | NFLAG | Per-flag update mask from the ALU |
| flag_i | input | NFLAG | New flag values |
| status_o | output | 8 | Stored status byte |
| pc_lo_i | input | 8 | Current program-counter low byte |
| pc_load_o | output | 1 | Request to load the program-counter low byte |
| pc_load_data_o | output | 8 | Value to load |

## Verification
`rdata_o`, `pc_load_o` and `pc_load_data_o` depend only on the present inputs and the stored state. The bench therefore checks them 1 ns after it drives the inputs, in the same cycle and before the rising edge. Pointer steps, RAM writes, bank changes and status updates appear after one edge. The reference model updates its own state just after that edge, and the next cycle's comparisons of `rdata_o` and `status_o` observe the result. Every cycle compares read data, status and the load request against the model. Pointer and bank values are read back through their direct offsets.

// File: rtl/banked_regfile_pkg.sv
package banked_regfile_pkg;

  // special offsets, identical in every bank; order is decoded behaviour
  typedef enum logic [3:0] {
    SLOT_IND      = 4'd0,
    SLOT_IND_PINC = 4'd1,
    SLOT_IND_PDEC = 4'd2,
    SLOT_IND_RINC = 4'd3,
    SLOT_IND_RDEC = 4'd4,
    SLOT_PTR      = 4'd5,
    SLOT_STAT     = 4'd6,
    SLOT_PCL      = 4'd7,
    SLOT_BANK     = 4'd8
  } slot_e;

  localparam int unsigned NUM_IND_SLOTS = 5;
  localparam int unsigned NUM_SLOTS     = 9;

  typedef enum logic [2:0] {
    TGT_NULL,
    TGT_PTR,
    TGT_STAT,
    TGT_PCL,
    TGT_BANK,
    TGT_RAM
  } tgt_e;

endpackage

// File: rtl/brf_addr_unit.sv
module brf_addr_unit
  import banked_regfile_pkg::*;
#(
  parameter int unsigned DIR_AW = 7,
  parameter int unsigned BANK_W = 1,
  localparam int unsigned TOT_AW = DIR_AW + BANK_W
) (
  input  logic [DIR_AW-1:0] addr_i,
  input  logic              access_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [TOT_AW-1:0] ptr_i,
  output logic [TOT_AW-1:0] ea_o,
  output tgt_e              tgt_o,
  output logic              step_en_o,
  output logic [TOT_AW-1:0] ptr_step_o
);

  logic [TOT_AW-1:0] ptr_inc, ptr_dec;
  logic [DIR_AW-1:0] off;
  logic              step_up;
  logic              is_step;

  assign ptr_inc = ptr_i + TOT_AW'(1);
  assign ptr_dec = ptr_i - TOT_AW'(1);

  always_comb begin
    ea_o    = {bank_i, addr_i};
    is_step = 1'b0;
    step_up = 1'b0;
    if (addr_i == DIR_AW'(SLOT_IND)) begin
      ea_o = ptr_i;
    end else if (addr_i == DIR_AW'(SLOT_IND_PINC)) begin
      ea_o    = ptr_i;
      is_step = 1'b1;
      step_up = 1'b1;
    end else if (addr_i == DIR_AW'(SLOT_IND_PDEC)) begin
      ea_o    = ptr_i;
      is_step = 1'b1;
    end else if (addr_i == DIR_AW'(SLOT_IND_RINC)) begin
      ea_o    = ptr_inc;
      is_step = 1'b1;
      step_up = 1'b1;
    end else if (addr_i == DIR_AW'(SLOT_IND_RDEC)) begin
      ea_o    = ptr_dec;
      is_step = 1'b1;
    end
  end

  assign step_en_o  = is_step & access_i;
  assign ptr_step_o = step_up ? ptr_inc : ptr_dec;

  // target decode on the offset inside whatever bank the address lands in
  assign off = ea_o[DIR_AW-1:0];

  always_comb begin
    if (off < DIR_AW'(NUM_IND_SLOTS))   tgt_o = TGT_NULL;
    else if (off == DIR_AW'(SLOT_PTR))  tgt_o = TGT_PTR;
    else if (off == DIR_AW'(SLOT_STAT)) tgt_o = TGT_STAT;
    else if (off == DIR_AW'(SLOT_PCL))  tgt_o = TGT_PCL;
    else if (off == DIR_AW'(SLOT_BANK)) tgt_o = TGT_BANK;
    else                                tgt_o = TGT_RAM;
  end

endmodule

// File: rtl/brf_ctrl_regs.sv
module brf_ctrl_regs
  import banked_regfile_pkg::*;
#(
  parameter int unsigned DIR_AW = 7,
  parameter int unsigned BANK_W = 1,
  parameter int unsigned NFLAG  = 3,
  localparam int unsigned TOT_AW = DIR_AW + BANK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [7:0]        wdata_i,
  input  tgt_e              tgt_i,
  input  logic              step_en_i,
  input  logic [TOT_AW-1:0] ptr_step_i,
  input  logic [NFLAG-1:0]  flag_we_i,
  input  logic [NFLAG-1:0]  flag_i,
  output logic [TOT_AW-1:0] ptr_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [7:0]        stat_o
);

  logic [TOT_AW-1:0] ptr_q, ptr_d;
  logic [BANK_W-1:0] bank_q, bank_d;
  logic [7:0]        stat_q, stat_d;

  // data write to the pointer overrides its own step
  always_comb begin
    ptr_d = ptr_q;
    if (step_en_i) ptr_d = ptr_step_i;
    if (we_i && tgt_i == TGT_PTR) ptr_d = wdata_i[TOT_AW-1:0];
  end

  always_comb begin
    bank_d = bank_q;
    if (we_i && tgt_i == TGT_BANK) bank_d = wdata_i[BANK_W-1:0];
  end

  // flags the ALU touches win; the rest follow the core write
  always_comb begin
    stat_d = (we_i && tgt_i == TGT_STAT) ? wdata_i : stat_q;
    for (int i = 0; i < int'(NFLAG); i++) begin
      if (flag_we_i[i]) stat_d[i] = flag_i[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      bank_q <= '0;
      stat_q <= '0;
    end else begin
      ptr_q  <= ptr_d;
      bank_q <= bank_d;
      stat_q <= stat_d;
    end
  end

  assign ptr_o  = ptr_q;
  assign bank_o = bank_q;
  assign stat_o = stat_q;

endmodule

// File: rtl/brf_ram.sv
module brf_ram #(
  parameter int unsigned AW = 8,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o
);

  logic [7:0] mem_q [DEPTH];

  for (genvar g = 0; g < int'(DEPTH); g++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mem_q[g] <= '0;
      end else if (we_i && addr_i == AW'(g)) begin
        mem_q[g] <= wdata_i;
      end
    end
  end

  assign rdata_o = mem_q[addr_i];

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import banked_regfile_pkg::*;
#(
  parameter int unsigned DIR_AW = 7,
  parameter int unsigned BANK_W = 1,
  parameter int unsigned NFLAG  = 3,
  localparam int unsigned TOT_AW = DIR_AW + BANK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIR_AW-1:0] addr_i,
  input  logic              rd_en_i,
  input  logic              we_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic [NFLAG-1:0]  flag_we_i,
  input  logic [NFLAG-1:0]  flag_i,
  output logic [7:0]        status_o,
  input  logic [7:0]        pc_lo_i,
  output logic              pc_load_o,
  output logic [7:0]        pc_load_data_o
);

  logic [TOT_AW-1:0] ptr_q;
  logic [BANK_W-1:0] bank_q;
  logic [TOT_AW-1:0] ea;
  logic [TOT_AW-1:0] ptr_step;
  logic              step_en;
  tgt_e              tgt;
  logic [7:0]        ram_rdata;
  logic              ram_we;

  brf_addr_unit #(
    .DIR_AW (DIR_AW),
    .BANK_W (BANK_W)
  ) u_addr (
    .addr_i     (addr_i),
    .access_i   (rd_en_i | we_i),
    .bank_i     (bank_q),
    .ptr_i      (ptr_q),
    .ea_o       (ea),
    .tgt_o      (tgt),
    .step_en_o  (step_en),
    .ptr_step_o (ptr_step)
  );

  brf_ctrl_regs #(
    .DIR_AW (DIR_AW),
    .BANK_W (BANK_W),
    .NFLAG  (NFLAG)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (we_i),
    .wdata_i    (wdata_i),
    .tgt_i      (tgt),
    .step_en_i  (step_en),
    .ptr_step_i (ptr_step),
    .flag_we_i  (flag_we_i),
    .flag_i     (flag_i),
    .ptr_o      (ptr_q),
    .bank_o     (bank_q),
    .stat_o     (status_o)
  );

  assign ram_we = we_i && tgt == TGT_RAM;

  brf_ram #(
    .AW (TOT_AW)
  ) u_ram (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ram_we),
    .addr_i  (ea),
    .wdata_i (wdata_i),
    .rdata_o (ram_rdata)
  );

  always_comb begin
    case (tgt)
      TGT_PTR:  rdata_o = 8'(ptr_q);
      TGT_STAT: rdata_o = status_o;
      TGT_PCL:  rdata_o = pc_lo_i;
      TGT_BANK: rdata_o = 8'(bank_q);
      TGT_RAM:  rdata_o = ram_rdata;
      default:  rdata_o = '0;
    endcase
  end

  assign pc_load_o      = we_i && tgt == TGT_PCL;
  assign pc_load_data_o = wdata_i;

endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk #(
  parameter int unsigned DIR_AW = 7,
  parameter int unsigned BANK_W = 1,
  parameter int unsigned NFLAG  = 3,
  localparam int unsigned TOT_AW = DIR_AW + BANK_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DIR_AW-1:0] addr_i,
  input logic              rd_en_i,
  input logic              we_i,
  input logic [7:0]        wdata_i,
  input logic [7:0]        rdata_o,
  input logic [NFLAG-1:0]  flag_we_i,
  input logic [NFLAG-1:0]  flag_i,
  input logic [7:0]        status_o,
  input logic              pc_load_o,
  input logic [7:0]        pc_load_data_o,
  input logic [TOT_AW-1:0] ptr_q
);

  p_null_read_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == DIR_AW'(0) && ptr_q[DIR_AW-1:0] < DIR_AW'(5)) |-> rdata_o == 8'h00);

  p_post_inc_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !we_i && addr_i == DIR_AW'(1)) |=> ptr_q == $past(ptr_q) + TOT_AW'(1));

  p_pre_dec_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !we_i && addr_i == DIR_AW'(4)) |=> ptr_q == $past(ptr_q) - TOT_AW'(1));

  p_ptr_idle_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_en_i && !we_i) |=> $stable(ptr_q));

  p_flag_upd_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_we_i[0] |=> status_o[0] == $past(flag_i[0]));

  p_stat_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && flag_we_i == '0) |=> $stable(status_o));

  p_pc_load_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_load_o |-> (we_i && pc_load_data_o == wdata_i));

  p_bank_upper_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == DIR_AW'(8)) |-> (rdata_o >> BANK_W) == 8'h00);

endmodule

bind banked_regfile banked_regfile_chk #(
  .DIR_AW (DIR_AW),
  .BANK_W (BANK_W),
  .NFLAG  (NFLAG)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .addr_i         (addr_i),
  .rd_en_i        (rd_en_i),
  .we_i           (we_i),
  .wdata_i        (wdata_i),
  .rdata_o        (rdata_o),
  .flag_we_i      (flag_we_i),
  .flag_i         (flag_i),
  .status_o       (status_o),
  .pc_load_o      (pc_load_o),
  .pc_load_data_o (pc_load_data_o),
  .ptr_q          (ptr_q)
);

// File: tb/banked_regfile_bench.sv
`timescale 1ns/1ps
module banked_regfile_bench;
  localparam int DIR_AW = 7;
  localparam int BANK_W = 1;
  localparam int NFLAG  = 3;
  localparam int WIN    = 1 << DIR_AW;
  localparam int TOT    = 1 << (DIR_AW + BANK_W);

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [DIR_AW-1:0] addr_i = '0;
  logic              rd_en_i = 1'b0, we_i = 1'b0;
  logic [7:0]        wdata_i = '0;
  logic [7:0]        rdata_o;
  logic [NFLAG-1:0]  flag_we_i = '0, flag_i = '0;
  logic [7:0]        status_o;
  logic [7:0]        pc_lo_i = '0;
  logic              pc_load_o;
  logic [7:0]        pc_load_data_o;

  always #4 clk = ~clk;

  banked_regfile #(.DIR_AW(DIR_AW), .BANK_W(BANK_W), .NFLAG(NFLAG)) u_banked_regfile (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr_i), .rd_en_i(rd_en_i), .we_i(we_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .flag_we_i(flag_we_i), .flag_i(flag_i),
    .status_o(status_o), .pc_lo_i(pc_lo_i), .pc_load_o(pc_load_o),
    .pc_load_data_o(pc_load_data_o)
  );

  int total = 0, bad = 0;
  int m_mem [TOT];
  int m_ptr = 0, m_stat = 0, m_bank = 0;

  task automatic chk(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int m_ea(int a);
    case (a)
      0, 1, 2: return m_ptr;
      3:       return (m_ptr + 1) % TOT;
      4:       return (m_ptr + TOT - 1) % TOT;
      default: return m_bank * WIN + a;
    endcase
  endfunction

  function automatic int m_read(int ea, int pc);
    int off = ea % WIN;
    if (off <= 4) return 0;
    if (off == 5) return m_ptr;
    if (off == 6) return m_stat;
    if (off == 7) return pc;
    if (off == 8) return m_bank;
    return m_mem[ea];
  endfunction

  // one core cycle: drive at negedge, compare 1 ns later, update model after posedge
  task automatic cyc(string tag, int a, bit rd, bit we, int wd = 0,
                     int fwe = 0, int fl = 0, int pc = 0);
    int ea, off, exp_rd;
    addr_i = DIR_AW'(a); rd_en_i = rd; we_i = we; wdata_i = 8'(wd);
    flag_we_i = NFLAG'(fwe); flag_i = NFLAG'(fl); pc_lo_i = 8'(pc);
    #1;
    ea = m_ea(a); off = ea % WIN; exp_rd = m_read(ea, pc);
    chk(tag, "rdata", int'(rdata_o), exp_rd);
    chk("R8", "status", int'(status_o), m_stat);
    chk("R10", "pc_load", int'(pc_load_o), int'(we && off == 7));
    if (we && off == 7) chk("R10", "pc_load_data", int'(pc_load_data_o), wd);
    @(posedge clk);
    if ((rd || we) && a >= 1 && a <= 4)
      m_ptr = (a == 1 || a == 3) ? (m_ptr + 1) % TOT : (m_ptr + TOT - 1) % TOT;
    if (we) begin
      if (off == 5) m_ptr = wd % TOT;
      else if (off == 8) m_bank = wd % (1 << BANK_W);
      else if (off >= 9) m_mem[ea] = wd;
    end
    begin
      int s = (we && off == 6) ? wd : m_stat;
      for (int i = 0; i < NFLAG; i++)
        if (fwe[i]) s = fl[i] ? (s | (1 << i)) : (s & ~(1 << i));
      m_stat = s;
    end
    @(negedge clk);
    rd_en_i = 1'b0; we_i = 1'b0; flag_we_i = '0;
  endtask

  initial begin
    #(8 * 100000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < TOT; i++) m_mem[i] = 0;
    repeat (3) @(negedge clk);
    addr_i = 7'd8; #1;
    chk("R1", "bank during reset", int'(rdata_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    cyc("R1", 5, 1, 0);
    cyc("R1", 6, 1, 0);
    cyc("R1", 8, 1, 0);
    cyc("R1", 8'h20, 1, 0);
    // R2 direct RAM and banking, R12 bank register
    cyc("R2", 8'h20, 0, 1, 8'hA5);
    cyc("R2", 8'h20, 1, 0);
    cyc("R12", 8, 0, 1, 8'hFF);
    cyc("R12", 8, 1, 0);
    cyc("R2", 8'h20, 1, 0);
    cyc("R2", 8'h20, 0, 1, 8'h3C);
    cyc("R2", 8'h7F, 0, 1, 8'h77);
    // R3 specials in bank 1
    cyc("R3", 5, 0, 1, 8'hA0);
    cyc("R12", 8, 0, 1, 8'h00);
    cyc("R3", 5, 1, 0);
    cyc("R2", 8'h20, 1, 0);
    // R4 plain indirect bypasses bank
    cyc("R4", 0, 1, 0);
    cyc("R4", 0, 0, 1, 8'h11);
    cyc("R4", 0, 1, 0);
    cyc("R4", 5, 1, 0);
    // R5 post steps, R6 pre steps
    cyc("R5", 1, 1, 0);
    cyc("R5", 1, 0, 1, 8'h22);
    cyc("R5", 5, 1, 0);
    cyc("R5", 2, 1, 0);
    cyc("R6", 3, 1, 0);
    cyc("R6", 4, 1, 0);
    cyc("R6", 5, 1, 0);
    cyc("R6", 4, 0, 1, 8'h99);
    cyc("R6", 0, 1, 0);
    // wrap
    cyc("R5", 5, 0, 1, 8'hFF);
    cyc("R5", 1, 1, 0);
    cyc("R5", 5, 1, 0);
    cyc("R6", 4, 1, 0);
    cyc("R6", 5, 1, 0);
    // R13 idle on stepping slots
    cyc("R13", 1, 0, 0);
    cyc("R13", 3, 0, 0);
    cyc("R13", 5, 1, 0);
    // R7 pointer naming an indirect slot
    cyc("R7", 5, 0, 1, 8'h80);
    cyc("R7", 0, 1, 0);
    cyc("R7", 0, 0, 1, 8'h55);
    cyc("R7", 0, 1, 0);
    cyc("R7", 2, 0, 1, 8'h66);
    cyc("R7", 5, 1, 0);
    cyc("R7", 0, 1, 0);
    // R11 indirect write to pointer wins over step
    cyc("R11", 5, 0, 1, 8'h05);
    cyc("R11", 1, 0, 1, 8'h40);
    cyc("R11", 5, 1, 0);
    cyc("R11", 5, 0, 1, 8'h04);
    cyc("R11", 3, 0, 1, 8'h30);
    cyc("R11", 5, 1, 0);
    // R8 status and flags, R9 priority
    cyc("R8", 6, 0, 1, 8'hF0);
    cyc("R8", 6, 1, 0);
    cyc("R8", 6, 1, 0, 0, 3'b101, 3'b111);
    cyc("R8", 6, 1, 0);
    cyc("R9", 6, 0, 1, 8'h02, 3'b001, 3'b001);
    cyc("R9", 6, 1, 0);
    cyc("R9", 6, 0, 1, 8'hFF, 3'b110, 3'b000);
    cyc("R9", 6, 1, 0);
    cyc("R8", 5, 0, 1, 8'h86);
    cyc("R8", 0, 0, 1, 8'h80);
    cyc("R8", 0, 1, 0);
    // R10 program-counter low byte
    cyc("R10", 7, 1, 0, 0, 0, 0, 8'h5A);
    cyc("R10", 7, 0, 1, 8'h33, 0, 0, 8'h5A);
    cyc("R10", 5, 0, 1, 8'h87);
    cyc("R10", 0, 1, 0, 0, 0, 0, 8'hC3);
    cyc("R10", 0, 0, 1, 8'h44, 0, 0, 8'hC3);
    cyc("R2", 8'h7F, 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule